// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Claim and Complete

This block gathers level-sensitive interrupt lines from a set of sources and presents one prioritised request to a single processor. Each source has a software-programmed priority and an enable bit. The processor also programs a priority threshold. The controller latches every asserted line into a pending bit. It raises its request output whenever a pending, enabled source outranks the threshold, and it reports the identifier of the best such source next to that request.

Software takes ownership of an interrupt by reading the claim register. That read returns the winning identifier and, as a side effect, moves the source from pending to in-service. An in-service source cannot become pending again until software writes the same identifier back to the claim register. After that write, a line that is still asserted is latched as pending once more. Identifier 0 means that nothing is waiting. A separate one-bit register drives a software interrupt line to the processor.

All accesses use a plain bus with one access per cycle. Read data is combinational from the address in the same cycle, and writes take effect at the clock edge. The address map is sparse: the priority words start at 0x0, the pending words at 0x1000, the enable words at 0x2000, the threshold at 0x200000, the claim register at 0x200004 and the software interrupt at 0x4000000.

Top module: `irq_hub`

## Requirements
- R1: irqReq is high in the cycle after a source line rises, provided that source is enabled and its priority exceeds the threshold.
- R2: irqId gives the identifier of the highest-priority source among the eligible ones. When irqReq is low, irqId is 0.
- R3: When eligible sources have equal priority, the one with the smaller identifier is reported.
- R4: A source interrupts only when its priority is strictly greater than the threshold. A source with priority 0 never interrupts.
- R5: A high source line sets its pending bit at the next clock edge. Pending word w at 0x1000+4*w holds source 32*w+b in bit b.
- R6: A read of the claim register at 0x200004 returns the current irqId, or 0 when irqReq is low. A read that returns a non-zero identifier clears that source's pending bit and marks the source in-service.
- R7: While a source is in-service, its still-asserted line does not set its pending bit again.
- R8: Writing an in-service identifier to 0x200004 ends its service, and a line that is still high is pending again one cycle later. Writing an identifier that is not in service changes nothing.
- R9: Source 0 never becomes pending, whatever its line, priority or enable.
- R10: Writing the word at 0x4000000 sets swIrq to bit 0 of the data. A read of that word returns swIrq in bit 0.
- R11: Priority words at 4*n, enable words at 0x2000+4*w (bit b is source 32*w+b) and the threshold at 0x200000 read back the value written. Priorities and the threshold are 3 bits wide in bits [2:0], and all other bits read 0.
- R12: After reset every register reads 0. A read of an unmapped or misaligned address returns 0, and a write to one changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcLevel | input | SRC_COUNT | Level interrupt lines, bit i for source i |
| busAddr | input | ADDR_W | Byte address of the access |
| busWdata | input | DATA_W | Write data |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe; needed for a claim to take effect |
| busRdata | output | DATA_W | Combinational read data for busAddr |
| irqReq | output | 1 | Interrupt request to the processor |
| irqId | output | ID_W | Identifier of the winning source, 0 when idle |
| swIrq | output | 1 | Software interrupt line |

## Verification
The in-service and pending vectors are the state most likely to go wrong. An in-service bit that fails to set shows up one cycle after the claim as a pending bit that reappears in the pending word. An in-service bit that fails to clear shows up as a source that stays silent after its completion write, which the next pending-word read exposes. A fault in the arbiter's comparison or tie-break appears as a wrong irqId in the cycle after the lines settle, so the bench checks irqId at every change of line, threshold or claim state.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int IDX_W = 16;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_PRIO,
    RD_PEND,
    RD_EN,
    RD_THR,
    RD_CLAIM,
    RD_SW
  } rdSel_e;

  typedef struct packed {
    logic             prioWr;
    logic             enWr;
    logic             thrWr;
    logic             swWr;
    logic             claim;
    logic             complete;
    rdSel_e           rdSel;
    logic [IDX_W-1:0] idx;
  } strobe_t;
endpackage

// File: rtl/irq_hub_ctrl.sv
module irq_hub_ctrl
  import irq_hub_pkg::*;
#(
  parameter int SRC_COUNT = 32,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  output strobe_t           strobe
);
  localparam int WORDS = (SRC_COUNT + DATA_W - 1) / DATA_W;
  localparam logic [ADDR_W-1:0] PRIO_END   = ADDR_W'(4 * SRC_COUNT);
  localparam logic [ADDR_W-1:0] PEND_BASE  = ADDR_W'('h1000);
  localparam logic [ADDR_W-1:0] EN_BASE    = ADDR_W'('h2000);
  localparam logic [ADDR_W-1:0] THR_ADDR   = ADDR_W'('h200000);
  localparam logic [ADDR_W-1:0] CLAIM_ADDR = ADDR_W'('h200004);
  localparam logic [ADDR_W-1:0] SW_ADDR    = ADDR_W'('h4000000);
  localparam logic [ADDR_W-1:0] SPAN       = ADDR_W'(4 * WORDS);

  rdSel_e           sel;
  logic [ADDR_W-1:0] offset;
  logic             aligned;

  always_comb begin
    sel     = RD_NONE;
    offset  = '0;
    aligned = (busAddr[1:0] == 2'b00);
    if (aligned) begin
      if (busAddr < PRIO_END) begin
        sel    = RD_PRIO;
        offset = busAddr;
      end else if (busAddr >= PEND_BASE && busAddr < PEND_BASE + SPAN) begin
        sel    = RD_PEND;
        offset = busAddr - PEND_BASE;
      end else if (busAddr >= EN_BASE && busAddr < EN_BASE + SPAN) begin
        sel    = RD_EN;
        offset = busAddr - EN_BASE;
      end else if (busAddr == THR_ADDR) begin
        sel = RD_THR;
      end else if (busAddr == CLAIM_ADDR) begin
        sel = RD_CLAIM;
      end else if (busAddr == SW_ADDR) begin
        sel = RD_SW;
      end
    end
  end

  always_comb begin
    strobe.rdSel    = sel;
    strobe.idx      = IDX_W'(offset >> 2);
    strobe.prioWr   = busWe && (sel == RD_PRIO);
    strobe.enWr     = busWe && (sel == RD_EN);
    strobe.thrWr    = busWe && (sel == RD_THR);
    strobe.swWr     = busWe && (sel == RD_SW);
    strobe.complete = busWe && (sel == RD_CLAIM);
    strobe.claim    = busRe && (sel == RD_CLAIM);
  end
endmodule

// File: rtl/irq_hub_dp.sv
module irq_hub_dp
  import irq_hub_pkg::*;
#(
  parameter int SRC_COUNT = 32,
  parameter int PRIO_W    = 3,
  parameter int DATA_W    = 32,
  parameter int ID_W      = $clog2(SRC_COUNT)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SRC_COUNT-1:0] srcLevel,
  input  logic [DATA_W-1:0]    wdata,
  input  strobe_t              strobe,
  output logic [DATA_W-1:0]    rdata,
  output logic                 irqReq,
  output logic [ID_W-1:0]      irqId,
  output logic                 swIrq,
  output logic [SRC_COUNT-1:0] pendVec,
  output logic [SRC_COUNT-1:0] servVec
);
  localparam int SEL_W = $clog2(SRC_COUNT);

  logic [PRIO_W-1:0]    prio [SRC_COUNT];
  logic [SRC_COUNT-1:0] enable;
  logic [PRIO_W-1:0]    thresh;
  logic [SRC_COUNT-1:0] pend, serv, pendNext, servNext;
  logic                 found;
  logic [ID_W-1:0]      bestId;
  logic [PRIO_W-1:0]    bestPrio;

  // Arbitration: scan downward so an equal priority at a lower ID replaces the holder.
  always_comb begin
    found    = 1'b0;
    bestId   = '0;
    bestPrio = '0;
    for (int i = SRC_COUNT - 1; i >= 1; i--) begin
      if (pend[i] && enable[i] && (prio[i] > thresh) && (!found || prio[i] >= bestPrio)) begin
        found    = 1'b1;
        bestId   = ID_W'(i);
        bestPrio = prio[i];
      end
    end
  end

  assign irqReq = found;
  assign irqId  = bestId;

  // Gateway: pending/in-service next state per source.
  always_comb begin
    pendNext = pend;
    servNext = serv;
    for (int i = 0; i < SRC_COUNT; i++) begin
      if (strobe.complete && serv[i] && (wdata == DATA_W'(i))) servNext[i] = 1'b0;
      if (strobe.claim && found && (bestId == ID_W'(i))) begin
        pendNext[i] = 1'b0;
        servNext[i] = 1'b1;
      end else if ((i != 0) && srcLevel[i] && !serv[i]) begin
        pendNext[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend   <= '0;
      serv   <= '0;
      enable <= '0;
      thresh <= '0;
      swIrq  <= 1'b0;
      for (int i = 0; i < SRC_COUNT; i++) prio[i] <= '0;
    end else begin
      pend <= pendNext;
      serv <= servNext;
      if (strobe.thrWr) thresh <= wdata[PRIO_W-1:0];
      if (strobe.swWr) swIrq <= wdata[0];
      if (strobe.prioWr) prio[strobe.idx[SEL_W-1:0]] <= wdata[PRIO_W-1:0];
      for (int i = 0; i < SRC_COUNT; i++) begin
        if (strobe.enWr && (i / DATA_W == int'(strobe.idx))) enable[i] <= wdata[i % DATA_W];
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (strobe.rdSel)
      RD_PRIO:  rdata = DATA_W'(prio[strobe.idx[SEL_W-1:0]]);
      RD_PEND, RD_EN: begin
        for (int b = 0; b < DATA_W; b++) begin
          if (int'(strobe.idx) * DATA_W + b < SRC_COUNT)
            rdata[b] = (strobe.rdSel == RD_PEND) ? pend[int'(strobe.idx) * DATA_W + b]
                                                 : enable[int'(strobe.idx) * DATA_W + b];
        end
      end
      RD_THR:   rdata = DATA_W'(thresh);
      RD_CLAIM: rdata = DATA_W'(bestId);
      RD_SW:    rdata = DATA_W'(swIrq);
      default:  rdata = '0;
    endcase
  end

  assign pendVec = pend;
  assign servVec = serv;
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int SRC_COUNT = 32,
  parameter int PRIO_W    = 3,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  localparam int ID_W     = $clog2(SRC_COUNT)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SRC_COUNT-1:0] srcLevel,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  input  logic                 busWe,
  input  logic                 busRe,
  output logic [DATA_W-1:0]    busRdata,
  output logic                 irqReq,
  output logic [ID_W-1:0]      irqId,
  output logic                 swIrq
);
  strobe_t              strobe;
  logic [SRC_COUNT-1:0] pendVec;
  logic [SRC_COUNT-1:0] servVec;

  irq_hub_ctrl #(
    .SRC_COUNT(SRC_COUNT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) i_ctrl (
    .busAddr(busAddr), .busWe(busWe), .busRe(busRe), .strobe(strobe)
  );

  irq_hub_dp #(
    .SRC_COUNT(SRC_COUNT), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ID_W(ID_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .wdata(busWdata),
    .strobe(strobe), .rdata(busRdata), .irqReq(irqReq), .irqId(irqId),
    .swIrq(swIrq), .pendVec(pendVec), .servVec(servVec)
  );
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int SRC_COUNT = 32,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int ID_W      = 5
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [DATA_W-1:0]    busWdata,
  input logic                 busWe,
  input logic                 busRe,
  input logic                 irqReq,
  input logic [ID_W-1:0]      irqId,
  input logic                 swIrq,
  input logic [SRC_COUNT-1:0] pendVec,
  input logic [SRC_COUNT-1:0] servVec
);
  localparam logic [ADDR_W-1:0] CLAIM_ADDR = ADDR_W'('h200004);
  localparam logic [ADDR_W-1:0] SW_ADDR    = ADDR_W'('h4000000);

  logic [ID_W-1:0] compId;
  logic            compValid;
  assign compId    = busWdata[ID_W-1:0];
  assign compValid = (busWdata == DATA_W'(compId));

  assert_idle_id_R2: assert property (@(posedge clk) disable iff (!rstN)
    !irqReq |-> irqId == '0);

  assert_req_has_id_R2: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> irqId != '0);

  assert_src0_silent_R9: assert property (@(posedge clk) disable iff (!rstN)
    !pendVec[0]);

  assert_no_pend_in_service_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pendVec & servVec) == '0);

  assert_claim_marks_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr == CLAIM_ADDR && irqReq) |=> servVec[$past(irqId)] && !pendVec[$past(irqId)]);

  assert_complete_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && !busRe && busAddr == CLAIM_ADDR && compValid && servVec[compId]) |=> !servVec[$past(compId)]);

  assert_sw_follows_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == SW_ADDR) |=> swIrq == $past(busWdata[0]));
endmodule

bind irq_hub irq_hub_chk #(
  .SRC_COUNT(SRC_COUNT), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)
) i_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
  .busWe(busWe), .busRe(busRe), .irqReq(irqReq), .irqId(irqId),
  .swIrq(swIrq), .pendVec(pendVec), .servVec(servVec)
);

// File: tb/test_irq_hub.sv
module test_irq_hub;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PEND  = 32'h1000;
  localparam logic [31:0] ENA   = 32'h2000;
  localparam logic [31:0] THR   = 32'h200000;
  localparam logic [31:0] CLAIM = 32'h200004;
  localparam logic [31:0] SWI   = 32'h4000000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcLevel = '0;
  logic [31:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [31:0] busRdata;
  logic        irqReq;
  logic [4:0]  irqId;
  logic        swIrq;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_hub i_irq_hub (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .busAddr(busAddr),
    .busWdata(busWdata), .busWe(busWe), .busRe(busRe), .busRdata(busRdata),
    .irqReq(irqReq), .irqId(irqId), .swIrq(swIrq)
  );

  // Monitor: pops each expected item and compares it with the ports.
  initial begin
    forever begin
      item_t it;
      logic [31:0] act;
      wait (q.size() != 0);
      it = q.pop_front();
      case (it.kind)
        0:       act = busRdata;
        1:       act = {23'd0, irqReq, 3'd0, irqId};
        default: act = {31'd0, swIrq};
      endcase
      vectors++;
      if (act !== it.exp) begin
        misses++;
        $display("FAIL %s actual=0x%08h expected=0x%08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rdChk(input logic [31:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    busAddr = a; busRe = 1'b1;
    #1;
    it.kind = 0; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic irqChk(input logic req, input logic [4:0] id, input string tag);
    item_t it;
    @(negedge clk);
    #1;
    it.kind = 1; it.exp = {23'd0, req, 3'd0, id}; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic swChk(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    #1;
    it.kind = 2; it.exp = {31'd0, e}; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic setSrc(input logic [31:0] v);
    @(negedge clk);
    srcLevel = v;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R12: reset state
    rdChk(32'h14, 0, "R12 reset prio5");
    rdChk(PEND, 0, "R12 reset pending");
    rdChk(ENA, 0, "R12 reset enable");
    rdChk(THR, 0, "R12 reset threshold");
    rdChk(SWI, 0, "R12 reset swirq");
    irqChk(1'b0, 5'd0, "R12 reset irq");
    rdChk(CLAIM, 0, "R6 claim with nothing pending");

    // R11: configuration read-back
    wr(32'h0C, 2);
    wr(32'h1C, 32'hFD);
    wr(32'h28, 5);
    wr(32'h00, 7);
    wr(ENA, 32'h0000_1489);
    rdChk(32'h1C, 5, "R11 prio7 three-bit field");
    rdChk(32'h0C, 2, "R11 prio3 readback");
    rdChk(ENA, 32'h0000_1489, "R11 enable readback");

    // R4, R5, R9: priority-0 source and source 0
    setSrc(32'h0000_1001);
    irqChk(1'b0, 5'd0, "R4 priority zero never interrupts");
    rdChk(PEND, 32'h0000_1000, "R5 R9 pending bit12 only");

    setSrc(32'h0000_1009);
    irqChk(1'b1, 5'd3, "R1 single eligible source");
    setSrc(32'h0000_1089);
    irqChk(1'b1, 5'd7, "R2 higher priority wins");
    setSrc(32'h0000_1489);
    irqChk(1'b1, 5'd7, "R3 tie lower id wins");

    wr(THR, 5);
    irqChk(1'b0, 5'd0, "R4 equal to threshold blocked");
    rdChk(THR, 5, "R11 threshold readback");
    wr(THR, 4);
    irqChk(1'b1, 5'd7, "R4 above threshold passes");

    // R6, R7: claim
    rdChk(CLAIM, 7, "R6 claim returns winner");
    irqChk(1'b1, 5'd10, "R6 next winner after claim");
    rdChk(PEND, 32'h0000_1408, "R7 claimed source not repended");
    repeat (3) @(negedge clk);
    rdChk(PEND, 32'h0000_1408, "R7 still held while in service");

    // R8: completion
    wr(CLAIM, 20);
    rdChk(PEND, 32'h0000_1408, "R8 foreign completion ignored");
    wr(CLAIM, 7);
    rdChk(PEND, 32'h0000_1488, "R8 completion re-arms source");
    irqChk(1'b1, 5'd7, "R8 source interrupts again");
    rdChk(CLAIM, 7, "R6 second claim");
    setSrc(32'h0000_1409);
    wr(CLAIM, 7);
    rdChk(PEND, 32'h0000_1408, "R8 dropped line stays clear");

    // R10: software interrupt
    wr(SWI, 1);
    swChk(1'b1, "R10 swirq set");
    rdChk(SWI, 1, "R10 swirq readback");
    wr(SWI, 0);
    swChk(1'b0, "R10 swirq cleared");

    // R12: unmapped and misaligned
    wr(32'h3000, 32'hFFFF_FFFF);
    rdChk(32'h3000, 0, "R12 unmapped read zero");
    wr(32'h2001, 0);
    rdChk(ENA, 32'h0000_1489, "R12 misaligned write ignored");
    rdChk(32'h2002, 0, "R12 misaligned read zero");

    @(negedge clk);
    wait (q.size() == 0);
    #1;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule